// File: doc/BRIEF.md
# Timecode Interrupt Flag Controller

This block gathers event pulses from the timecode readers and from the video field detector. It holds them as sticky bits in one flag byte that the host can read. Five sources feed it: an update of the combined (mixed) timecode register, an update of the linear timecode register, an update of the vertical-interval timecode register, the start of a first (odd) field and the start of a second (even) field. A flag sets whenever its event occurs, whatever the mask, so software can poll the byte instead of taking interrupts.

A mask register selects which flags drive the single active-high interrupt line. The three register-update flags clear when the host reads the matching data register. The two field flags stay set until an explicit acknowledge command names them. When a set and a clear of the same flag fall in the same cycle, the set wins, so no event is lost.

Top module: `tc_irq_flags`

## Requirements
- R1: Each event pulse sets its flag bit in `flagByte`, and the bit is visible after the clock edge that samples the pulse. The bit positions are: mixed update at bit 0, linear update at bit 2, vertical-interval update at bit 3, first field at bit 6 and second field at bit 7.
- R2: A flag sets on its event whatever the value of the mask register.
- R3: `irqOut` is active high. One cycle after the flag byte and the mask register share a set bit, `irqOut` is high, and it is low otherwise.
- R4: A pulse on `rdMixed`, `rdLinear` or `rdVert` clears flag bit 0, 2 or 3 respectively. These read strobes leave every other flag unchanged.
- R5: Flag bits 6 and 7 clear only when `ackValid` is high and the matching bit of `ackBits` is 1. The `ackBits` bits at positions 0 to 5 are ignored, and the read strobes do not touch bits 6 and 7.
- R6: If a flag's event and its clear (a read or an acknowledge) arrive in the same cycle, the flag ends up set.
- R7: Bits 1, 4 and 5 of `flagByte` always read as zero. Mask bits written at those positions have no effect on `irqOut`.
- R8: After reset, `flagByte` is zero, the mask register is zero and `irqOut` is low.
- R9: When `maskWe` is high, the mask register loads `maskData` at that clock edge. The new mask acts on `irqOut` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evMixed | input | 1 | Mixed timecode register updated (one-cycle pulse) |
| evLinear | input | 1 | Linear timecode register updated |
| evVert | input | 1 | Vertical-interval timecode register updated |
| evField1 | input | 1 | First (odd) video field started |
| evField2 | input | 1 | Second (even) video field started |
| rdMixed | input | 1 | Host read of the mixed data register |
| rdLinear | input | 1 | Host read of the linear data register |
| rdVert | input | 1 | Host read of the vertical-interval data register |
| ackValid | input | 1 | Acknowledge command strobe |
| ackBits | input | 8 | Flags to acknowledge (only bits 6 and 7 act) |
| maskWe | input | 1 | Mask register write strobe |
| maskData | input | 8 | New mask value |
| flagByte | output | 8 | Current flag byte |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
Any flag set or clear from a pulse sampled at clock edge k shows on `flagByte` right after edge k. `irqOut` follows one edge later, at k+1, because it is registered from the flag and mask registers, and a mask write follows the same one-edge lag. The driver applies each stimulus just after a falling edge. It also computes the flag byte and interrupt level expected just after the next rising edge, pushing both into a queue. The monitor pops one item a short delay after every rising edge. Every comparison therefore lands after the registers have settled and before the next stimulus changes.

// File: rtl/tcirq_pkg.sv
package tcirq_pkg;
  localparam int FLAG_W   = 8;
  localparam int BIT_MIX  = 0;
  localparam int BIT_LIN  = 2;
  localparam int BIT_VERT = 3;
  localparam int BIT_FLD1 = 6;
  localparam int BIT_FLD2 = 7;

  function automatic logic [FLAG_W-1:0] bitOf(input int idx);
    logic [FLAG_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // flags cleared by a data register read
  localparam logic [FLAG_W-1:0] READ_CLR_MASK = bitOf(BIT_MIX) | bitOf(BIT_LIN) | bitOf(BIT_VERT);
  // flags cleared by the acknowledge command
  localparam logic [FLAG_W-1:0] ACK_CLR_MASK  = bitOf(BIT_FLD1) | bitOf(BIT_FLD2);
  // implemented flag positions
  localparam logic [FLAG_W-1:0] LIVE_MASK     = READ_CLR_MASK | ACK_CLR_MASK;

  typedef struct packed {
    logic [FLAG_W-1:0] setVec;
    logic [FLAG_W-1:0] clrVec;
    logic              maskLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/tcirq_ctrl.sv
module tcirq_ctrl
  import tcirq_pkg::*;
(
  input  logic              evMixed,
  input  logic              evLinear,
  input  logic              evVert,
  input  logic              evField1,
  input  logic              evField2,
  input  logic              rdMixed,
  input  logic              rdLinear,
  input  logic              rdVert,
  input  logic              ackValid,
  input  logic [FLAG_W-1:0] ackBits,
  input  logic              maskWe,
  output ctrlStrobe_t       strobe
);
  logic [FLAG_W-1:0] readClr;
  logic [FLAG_W-1:0] ackClr;

  always_comb begin
    strobe = '0;
    strobe.setVec[BIT_MIX]  = evMixed;
    strobe.setVec[BIT_LIN]  = evLinear;
    strobe.setVec[BIT_VERT] = evVert;
    strobe.setVec[BIT_FLD1] = evField1;
    strobe.setVec[BIT_FLD2] = evField2;

    readClr = '0;
    readClr[BIT_MIX]  = rdMixed;
    readClr[BIT_LIN]  = rdLinear;
    readClr[BIT_VERT] = rdVert;

    ackClr = ackValid ? (ackBits & ACK_CLR_MASK) : '0;

    strobe.clrVec   = (readClr & READ_CLR_MASK) | ackClr;
    strobe.maskLoad = maskWe;
  end
endmodule

// File: rtl/tcirq_datapath.sv
module tcirq_datapath
  import tcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [FLAG_W-1:0] maskData,
  output logic [FLAG_W-1:0] flagQ,
  output logic              irqQ
);
  logic [FLAG_W-1:0] maskQ;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (LIVE_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN)                  flagQ[i] <= 1'b0;
        else if (strobe.setVec[i])  flagQ[i] <= 1'b1;
        else if (strobe.clrVec[i])  flagQ[i] <= 1'b0;
        if (!rstN)                  maskQ[i] <= 1'b0;
        else if (strobe.maskLoad)   maskQ[i] <= maskData[i];
      end
    end else begin : g_dead
      assign flagQ[i] = 1'b0;
      assign maskQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(flagQ & maskQ);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setVec[BIT_LIN] |=> flagQ[BIT_LIN]); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(flagQ != '0)); // R3
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !irqQ); // R3
endmodule

// File: rtl/tc_irq_flags.sv
module tc_irq_flags
  import tcirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evMixed,
  input  logic       evLinear,
  input  logic       evVert,
  input  logic       evField1,
  input  logic       evField2,
  input  logic       rdMixed,
  input  logic       rdLinear,
  input  logic       rdVert,
  input  logic       ackValid,
  input  logic [7:0] ackBits,
  input  logic       maskWe,
  input  logic [7:0] maskData,
  output logic [7:0] flagByte,
  output logic       irqOut
);
  ctrlStrobe_t strobe;

  tcirq_ctrl u_ctrl (
    .evMixed  (evMixed),
    .evLinear (evLinear),
    .evVert   (evVert),
    .evField1 (evField1),
    .evField2 (evField2),
    .rdMixed  (rdMixed),
    .rdLinear (rdLinear),
    .rdVert   (rdVert),
    .ackValid (ackValid),
    .ackBits  (ackBits),
    .maskWe   (maskWe),
    .strobe   (strobe)
  );

  tcirq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .maskData (maskData),
    .flagQ    (flagByte),
    .irqQ     (irqOut)
  );

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagByte & ~LIVE_MASK) == '0); // R7
  AST_FIELD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagByte[BIT_FLD1] && !ackValid) |=> flagByte[BIT_FLD1]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdVert && !evVert) |=> !flagByte[BIT_VERT]); // R4
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    evMixed |=> flagByte[BIT_MIX]); // R1
endmodule

// File: tb/sim_tc_irq_flags.sv
module sim_tc_irq_flags;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] flags;
    logic       irq;
    string      req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evMixed = 0, evLinear = 0, evVert = 0, evField1 = 0, evField2 = 0;
  logic rdMixed = 0, rdLinear = 0, rdVert = 0, ackValid = 0, maskWe = 0;
  logic [7:0] ackBits = '0, maskData = '0;
  logic [7:0] flagByte;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  expItem_t expQ[$];

  logic [7:0] mFlags = '0, mMask = '0;
  logic mIrq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_irq_flags u0 (.*);

  // driver: apply one cycle of stimulus, push what must appear after the next rising edge
  task automatic step(input logic [7:0] ev, input logic [7:0] rd, input logic ackV,
                      input logic [7:0] ackB, input logic mWe, input logic [7:0] mD,
                      input string req);
    logic nextIrq;
    logic [7:0] clr;
    expItem_t it;
    @(negedge clk);
    evMixed = ev[0]; evLinear = ev[2]; evVert = ev[3]; evField1 = ev[6]; evField2 = ev[7];
    rdMixed = rd[0]; rdLinear = rd[2]; rdVert = rd[3];
    ackValid = ackV; ackBits = ackB; maskWe = mWe; maskData = mD;
    nextIrq = |(mFlags & mMask);
    clr = (rd & 8'h0D) | (ackV ? (ackB & 8'hC0) : 8'h00);
    mFlags = (mFlags & ~clr) | (ev & 8'hCD);
    if (mWe) mMask = mD & 8'hCD;
    mIrq = nextIrq;
    it.flags = mFlags; it.irq = mIrq; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idle(input string req);
    step(8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, req);
  endtask

  // monitor: compare after each rising edge once registers have settled
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (flagByte !== e.flags || irqOut !== e.irq) begin
        errors++;
        $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
                 e.req, flagByte, irqOut, e.flags, e.irq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state
    checks++;
    if (flagByte !== 8'h00 || irqOut !== 1'b0) begin
      errors++;
      $display("FAIL R8: flags=%h irq=%b expected flags=00 irq=0", flagByte, irqOut);
    end

    // R1 / R2: each event sets its bit with the mask at zero, no interrupt
    step(8'h01, 8'h00, 0, 8'h00, 0, 8'h00, "R1 mixed bit0");
    step(8'h04, 8'h00, 0, 8'h00, 0, 8'h00, "R1 linear bit2");
    step(8'h08, 8'h00, 0, 8'h00, 0, 8'h00, "R1 vert bit3");
    step(8'h40, 8'h00, 0, 8'h00, 0, 8'h00, "R1 field1 bit6");
    step(8'h80, 8'h00, 0, 8'h00, 0, 8'h00, "R2 field2 bit7 mask zero");
    idle("R2 flags held, irq low");

    // R7: mask written only at reserved positions has no effect
    step(8'h00, 8'h00, 0, 8'h00, 1, 8'h32, "R7 reserved mask write");
    idle("R7 irq stays low");
    idle("R7 irq stays low 2");

    // R4: reads clear their own flags only
    step(8'h00, 8'h04, 0, 8'h00, 0, 8'h00, "R4 read linear");
    step(8'h00, 8'h09, 0, 8'h00, 0, 8'h00, "R4 read mixed and vert");

    // R5: ack at bits 0..5 ignored, reads leave fields, ack bit6 clears
    step(8'h0D, 8'h00, 0, 8'h00, 0, 8'h00, "R5 restore register flags");
    step(8'h00, 8'h00, 1, 8'h3F, 0, 8'h00, "R5 low ack bits ignored");
    step(8'h00, 8'h0D, 0, 8'h00, 0, 8'h00, "R5 reads keep field flags");
    step(8'h00, 8'h00, 0, 8'hC0, 0, 8'h00, "R5 ack bits without strobe");
    step(8'h00, 8'h00, 1, 8'h40, 0, 8'h00, "R5 ack field1");

    // R6: set beats clear
    step(8'h84, 8'h04, 1, 8'h80, 0, 8'h00, "R6 set and clear same cycle");
    idle("R6 flags held");

    // R9 / R3: enable mask, irq one cycle after mask load
    step(8'h00, 8'h00, 0, 8'h00, 1, 8'h04, "R9 mask load linear");
    idle("R3 irq rises");
    step(8'h00, 8'h04, 0, 8'h00, 0, 8'h00, "R3 read linear clears");
    idle("R3 irq falls after flag clears");
    step(8'h00, 8'h00, 1, 8'h80, 1, 8'hC1, "R9 mask fields and mixed");
    step(8'h40, 8'h00, 0, 8'h00, 0, 8'h00, "R3 field1 event unmasked");
    idle("R3 irq from field1");
    step(8'h00, 8'h00, 1, 8'h40, 1, 8'h00, "R9 mask cleared, ack field1");
    idle("R3 irq low after mask off");
    step(8'h01, 8'h00, 0, 8'h00, 1, 8'h01, "R2 mixed with mask load");
    idle("R3 irq from mixed");
    idle("R3 irq holds");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule